// File: doc/BRIEF.md
# Significand Rounding Selector

This block finishes a floating-point result by rounding a significand that has already been cut to the target precision. It receives the sign of the value, the kept significand bits, a guard bit (the first discarded bit) and a sticky bit (the OR of every discarded bit below the guard). A two-bit mode code picks the rounding direction. From these the block decides whether the kept bits stand as they are or are raised by one unit in the last place.

The raised value is the next representable neighbour away from zero. For a positive value that neighbour is the larger one, and for a negative value it is the smaller one. The directed modes therefore use the sign to decide whether they increment. The block also reports whether any precision was lost. It raises a carry when the kept field was all ones and was raised, so the caller can shift the significand right and adjust the exponent.

Exponent handling and special values belong to the surrounding datapath. The decision logic is combinational. A parameter adds one output register stage, which is enabled by default.

Top module: `rnd_select`

## Requirements
- R1: With the output stage enabled, each result appears on the outputs one clock after its inputs. While reset is asserted, all outputs are zero.
- R2: When guard and sticky are both 0, the output significand equals the input significand, and carry and inexact are both 0, in every mode.
- R3: In mode 2'b00 (nearest), the significand is raised by one when guard=1 and sticky=1. It is left unchanged when guard=0.
- R4: In mode 2'b00, on a tie (guard=1, sticky=0), the significand is raised exactly when its bit 0 is 1, so the result always has bit 0 equal to 0.
- R5: In mode 2'b01 (toward zero), the significand is never raised.
- R6: In mode 2'b10 (toward +infinity), the significand is raised exactly when sign=0 and guard or sticky is 1.
- R7: In mode 2'b11 (toward -infinity), the significand is raised exactly when sign=1 and guard or sticky is 1.
- R8: The inexact output equals guard OR sticky, whatever the mode and the sign.
- R9: When an all-ones significand is raised, carry is 1 and the output significand is all zeros. Carry is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| frac_i | input | WIDTH | Significand cut after its LSB |
| guard_i | input | 1 | First discarded bit |
| sticky_i | input | 1 | OR of the discarded bits below guard |
| mode_i | input | 2 | Rounding mode code |
| frac_o | output | WIDTH | Rounded significand |
| carry_o | output | 1 | Increment overflowed the significand |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
Carry-out and inexact fall in the same cycle whenever an all-ones significand is raised. In nearest mode, a tie on an all-ones field also makes the tie-to-even rule and the carry coincide. The bench provokes these cases with directed all-ones vectors in every mode and sign, and with random vectors biased towards all-ones fields. A behavioural model works out the rounded value as an integer sum and takes the carry and the significand from that sum. The model's results are queued and compared with the outputs one clock later.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  input  rmode_e mode_i,
  output logic   bump_o,
  output logic   lost_o
);
  logic lost;

  assign lost = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: bump_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO: bump_o = 1'b0;
      RM_PINF: bump_o = lost & ~sign_i;
      RM_NINF: bump_o = lost & sign_i;
      default: bump_o = 1'b0;
    endcase
  end

  assign lost_o = lost;

  // Exact inputs never move.
  always_comb assert_exact_hold_R2: assert (lost || !bump_o);
  // Truncation mode never raises.
  always_comb assert_zero_mode_R5: assert (mode_i != RM_ZERO || !bump_o);
  // Directed modes only raise on the matching sign.
  always_comb assert_pinf_sign_R6: assert (mode_i != RM_PINF || !(bump_o && sign_i));
  always_comb assert_ninf_sign_R7: assert (mode_i != RM_NINF || !(bump_o && !sign_i));
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] frac_i,
  input  logic             bump_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = bump_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]     = frac_i[i] ^ chain[i];
    assign chain[i+1]   = frac_i[i] & chain[i];
  end

  assign carry_o = chain[WIDTH];

  // A carry leaves an all-zero field and needs a raise.
  always_comb assert_wrap_zero_R9: assert (!carry_o || (sum_o == '0 && bump_i));
endmodule

// File: rtl/rnd_select.sv
module rnd_select
  import rnd_pkg::*;
#(
  parameter int WIDTH   = 24,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_i,
  input  logic [WIDTH-1:0] frac_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] frac_o,
  output logic             carry_o,
  output logic             inexact_o
);
  logic             bump;
  logic             lost;
  logic [WIDTH-1:0] sum_d;
  logic             carry_d;

  rnd_decide u_decide (
    .sign_i   (sign_i),
    .lsb_i    (frac_i[0]),
    .guard_i  (guard_i),
    .sticky_i (sticky_i),
    .mode_i   (rmode_e'(mode_i)),
    .bump_o   (bump),
    .lost_o   (lost)
  );

  rnd_incr #(.WIDTH(WIDTH)) u_incr (
    .frac_i  (frac_i),
    .bump_i  (bump),
    .sum_o   (sum_d),
    .carry_o (carry_d)
  );

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] frac_q;
    logic             carry_q;
    logic             inex_q;
    logic             primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frac_q   <= '0;
        carry_q  <= 1'b0;
        inex_q   <= 1'b0;
        primed_q <= 1'b0;
      end else begin
        frac_q   <= sum_d;
        carry_q  <= carry_d;
        inex_q   <= lost;
        primed_q <= 1'b1;
      end
    end

    assign frac_o    = frac_q;
    assign carry_o   = carry_q;
    assign inexact_o = inex_q;

    assert_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> (inexact_o == ($past(guard_i) | $past(sticky_i))));

    assert_exact_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !$past(guard_i) && !$past(sticky_i))
        |-> (frac_o == $past(frac_i) && !carry_o));

    assert_even_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(mode_i) == 2'b00 && $past(guard_i) && !$past(sticky_i))
        |-> !frac_o[0]);
  end else begin : g_comb
    assign frac_o    = sum_d;
    assign carry_o   = carry_d;
    assign inexact_o = lost;
  end
endmodule

// File: tb/test_rnd_select.sv
module test_rnd_select;
  localparam int W = 10;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sign_i, guard_i, sticky_i;
  logic [W-1:0] frac_i;
  logic [1:0]   mode_i;
  logic [W-1:0] frac_o;
  logic         carry_o, inexact_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  string tag_q[$];
  int inex_q[$];

  always #10 clk = ~clk;

  rnd_select #(.WIDTH(W), .OUT_REG(1'b1)) i_rnd_select (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .frac_i(frac_i),
    .guard_i(guard_i), .sticky_i(sticky_i), .mode_i(mode_i),
    .frac_o(frac_o), .carry_o(carry_o), .inexact_o(inexact_o)
  );

  function automatic int model(input int s, input int f, input int g,
                               input int st, input int m, output string tag);
    int inc;
    int lost;
    lost = (g | st);
    inc = 0;
    case (m)
      0: inc = (g != 0 && (st != 0 || (f % 2) == 1)) ? 1 : 0;
      1: inc = 0;
      2: inc = (lost != 0 && s == 0) ? 1 : 0;
      default: inc = (lost != 0 && s == 1) ? 1 : 0;
    endcase
    if (lost == 0) tag = "R2";
    else if (f + inc > MAXV) tag = "R9";
    else if (m == 0) tag = (st == 0) ? "R4" : "R3";
    else if (m == 1) tag = "R5";
    else if (m == 2) tag = "R6";
    else tag = "R7";
    return f + inc;
  endfunction

  task automatic apply(input int s, input int f, input int g, input int st, input int m);
    string tag;
    int e;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      int ev;
      string et;
      int ei;
      ev = exp_q.pop_front();
      et = tag_q.pop_front();
      ei = inex_q.pop_front();
      total++;
      if ({carry_o, frac_o} != (W+1)'(ev)) begin
        bad++;
        $display("FAIL %s: carry/frac got %0d/%0d expected %0d/%0d", et,
                 carry_o, frac_o, ev >> W, ev & MAXV);
      end
      total++;
      if (inexact_o != ei[0]) begin
        bad++;
        $display("FAIL R8: inexact got %0d expected %0d", inexact_o, ei);
      end
    end
    sign_i = s[0]; frac_i = W'(f); guard_i = g[0]; sticky_i = st[0]; mode_i = m[1:0];
    e = model(s, f, g, st, m, tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    inex_q.push_back(g | st);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sign_i = 0; frac_i = '1; guard_i = 1; sticky_i = 1; mode_i = 0;
    repeat (3) @(negedge clk);
    total++;
    if (frac_o != '0 || carry_o || inexact_o) begin
      bad++;
      $display("FAIL R1: reset outputs got %0d/%0d/%0d expected 0/0/0", frac_o, carry_o, inexact_o);
    end
    rst_n = 1'b1;
    // R2 exact in all modes and signs
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++) begin
        apply(s, 341, 0, 0, m);
        apply(s, MAXV, 0, 0, m);
      end
    // R3 R4 R5 R6 R7 and R9 over all guard/sticky/sign/lsb mixes
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int gs = 1; gs < 4; gs++) begin
          apply(s, 100, gs >> 1, gs & 1, m);
          apply(s, 101, gs >> 1, gs & 1, m);
          apply(s, MAXV, gs >> 1, gs & 1, m);
          apply(s, MAXV - 1, gs >> 1, gs & 1, m);
        end
    // random, biased to all-ones fields (R9 with R8)
    for (int i = 0; i < 3000; i++) begin
      int f;
      f = ($urandom % 4 == 0) ? MAXV : int'($urandom % (MAXV + 1));
      apply($urandom % 2, f, $urandom % 2, $urandom % 2, $urandom % 4);
    end
    apply(0, 0, 0, 0, 0);
    // R1 latency: one further edge flushes the final queued result
    apply(0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule